// File: doc/BRIEF.md
# Serial-to-RAM Slave Access Port

This block lets an external serial master read and write an on-chip byte RAM, and post messages to the local processor. It connects to the master through four pins: an active-low select, a serial clock, a serial input and a serial output with its own output enable. On the chip side it drives a parallel RAM bus with a 16-bit address. The RAM returns read data one system clock after a read strobe.

Every pin is brought into the system clock domain through a two-flop synchronizer. Clock edges are then found by comparing successive samples. Each serial clock phase must therefore last at least four system clock cycles; at 200 MHz this leaves a wide margin for a 1 Mb/s link.

A frame is one command byte, then a 16-bit address, then data bytes, all most-significant bit first. The command chooses a read burst, a write burst or a mailbox message. It also chooses whether the processor is interrupted when the select line rises. The last command and the last address stay visible to the processor after the frame ends.

Top module: `spi_mem_port`

## Requirements
- R1: While `spi_csn` is high, `spi_miso_oe` is low and toggling `spi_sck` or `spi_mosi` causes no RAM strobe, no interrupt and no change of `cpu_last_cmd` or `cpu_last_addr`.
- R2: After `spi_csn` falls, the first 8 rising `spi_sck` edges shift in the command and the next 16 shift in the address, MSB first. `cpu_last_cmd` takes the command once its 8th bit is sampled. `cpu_last_addr` takes the address once its 16th bit is sampled.
- R3: A command whose two top bits are `11` is a read burst. Bytes from the address and the addresses after it, incrementing by one and wrapping at 16 bits, appear on `spi_miso` MSB first. Each bit changes after a falling `spi_sck` edge. The first bit is valid before the 25th rising edge.
- R4: A command whose two top bits are `10` is a write burst. Each complete received byte gives one single-cycle `mem_wr_en` pulse with that byte. The first pulse uses the frame address, and each later pulse uses the next address, wrapping at 16 bits.
- R5: A data byte that is cut off by `spi_csn` rising before its 8th bit produces no write strobe.
- R6: A command whose top bit is `0` is a mailbox message. It never strobes the RAM, and its data bytes are ignored.
- R7: When `spi_csn` rises after a complete command byte, `cpu_irq` gives exactly one one-cycle pulse. The exceptions are the exact values `8'hC0` and `8'h80`, which raise no interrupt. A frame of the command byte alone also interrupts.
- R8: A frame that ends before 8 command bits gives no interrupt and leaves `cpu_last_cmd` unchanged. A frame that ends before 24 header bits leaves `cpu_last_addr` unchanged and performs no RAM access.
- R9: `spi_miso_oe` is high only during the data phase of a read burst. It stays low during every header bit and during write or mailbox frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (low means high-impedance) |
| mem_addr | output | 16 | RAM byte address |
| mem_rd_en | output | 1 | RAM read strobe, data expected on the next cycle |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data |
| cpu_irq | output | 1 | One-cycle interrupt pulse to the processor |
| cpu_last_cmd | output | 8 | Last complete command byte |
| cpu_last_addr | output | 16 | Last complete address |

## Verification
The hardest cases to reach are frames cut off at awkward points. These include a select rise in the middle of a data byte, in the middle of the address, or in the middle of the command byte. Each of these must leave the interrupt, the visible registers and the RAM strobes in exactly the right state. The bench drives frames from a task that takes an exact bit count, so any truncation point can be chosen. Before each frame it builds queues of the expected RAM strobes, including the extra prefetch read at the end of a read burst. A per-clock monitor pops these queues in order, and any unexpected or missing strobe is reported.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [1:0] {
    KIND_MAILBOX = 2'd0,
    KIND_WRITE   = 2'd1,
    KIND_READ    = 2'd2
  } cmd_kind_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          N_PINS  = 3,
  parameter int          STAGES  = 2,
  parameter logic [N_PINS-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_sync
);

  genvar gp;
  generate
    for (gp = 0; gp < N_PINS; gp++) begin : g_pin
      logic [STAGES-1:0] pipe_q;
      logic [STAGES-1:0] pipe_n;

      always_comb begin
        pipe_n = {pipe_q[STAGES-2:0], pin_in[gp]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q <= {STAGES{RST_VAL[gp]}};
        end else begin
          pipe_q <= pipe_n;
        end
      end

      assign pin_sync[gp] = pipe_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_end,
  input  logic              sck_rise,
  input  logic              mosi_bit,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq,
  output logic [DATA_W-1:0] last_cmd,
  output logic [ADDR_W-1:0] last_addr,
  output logic              data_phase,
  output logic [$clog2(DATA_W)-1:0] bit_idx,
  output logic              is_read
);

  localparam int CMD_W = DATA_W;
  localparam int HDR   = CMD_W + ADDR_W;
  localparam int CNT_W = $clog2(HDR + 1);
  localparam int BIT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  hdr_q, hdr_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic [ADDR_W-1:0] sh_q, sh_n, shin;
  logic [CMD_W-1:0]  cmd_q, cmd_n;
  logic              cmd_ok_q, cmd_ok_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              rd_q, rd_n, wr_q, wr_n, irq_q, irq_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic [CMD_W-1:0]  lcmd_q, lcmd_n;
  logic [ADDR_W-1:0] laddr_q, laddr_n;
  cmd_kind_e         kind;
  logic              quiet_cmd;

  // Command decode: top bit 0 is a mailbox, 10 a write, 11 a read.
  always_comb begin
    if (!cmd_q[CMD_W-1])      kind = KIND_MAILBOX;
    else if (cmd_q[CMD_W-2])  kind = KIND_READ;
    else                      kind = KIND_WRITE;
    quiet_cmd = cmd_q[CMD_W-1] && (cmd_q[CMD_W-3:0] == '0);
  end

  always_comb begin
    hdr_n    = hdr_q;
    bit_n    = bit_q;
    sh_n     = sh_q;
    cmd_n    = cmd_q;
    cmd_ok_n = cmd_ok_q;
    ptr_n    = ptr_q;
    addr_n   = addr_q;
    wdata_n  = wdata_q;
    lcmd_n   = lcmd_q;
    laddr_n  = laddr_q;
    rd_n     = 1'b0;
    wr_n     = 1'b0;
    irq_n    = cs_end && cmd_ok_q && !quiet_cmd;
    shin     = {sh_q[ADDR_W-2:0], mosi_bit};
    if (!cs_act) begin
      hdr_n    = '0;
      bit_n    = '0;
      cmd_ok_n = 1'b0;
    end else if (sck_rise) begin
      sh_n = shin;
      if (hdr_q != CNT_W'(HDR)) begin
        hdr_n = hdr_q + CNT_W'(1);
        if (hdr_q == CNT_W'(CMD_W - 1)) begin
          cmd_n    = shin[CMD_W-1:0];
          cmd_ok_n = 1'b1;
          lcmd_n   = shin[CMD_W-1:0];
        end
        if (hdr_q == CNT_W'(HDR - 1)) begin
          laddr_n = shin;
          addr_n  = shin;
          if (kind == KIND_READ) begin
            rd_n  = 1'b1;
            ptr_n = shin + ADDR_W'(1);
          end else begin
            ptr_n = shin;
          end
        end
      end else begin
        bit_n = bit_q + BIT_W'(1);
        if (bit_q == BIT_W'(DATA_W - 1)) begin
          bit_n = '0;
          if (kind == KIND_WRITE) begin
            wr_n    = 1'b1;
            addr_n  = ptr_q;
            wdata_n = shin[DATA_W-1:0];
            ptr_n   = ptr_q + ADDR_W'(1);
          end else if (kind == KIND_READ) begin
            rd_n   = 1'b1;
            addr_n = ptr_q;
            ptr_n  = ptr_q + ADDR_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      cmd_q    <= '0;
      cmd_ok_q <= 1'b0;
      ptr_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      lcmd_q   <= '0;
      laddr_q  <= '0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      hdr_q    <= hdr_n;
      bit_q    <= bit_n;
      sh_q     <= sh_n;
      cmd_q    <= cmd_n;
      cmd_ok_q <= cmd_ok_n;
      ptr_q    <= ptr_n;
      addr_q   <= addr_n;
      wdata_q  <= wdata_n;
      lcmd_q   <= lcmd_n;
      laddr_q  <= laddr_n;
      rd_q     <= rd_n;
      wr_q     <= wr_n;
      irq_q    <= irq_n;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_rd_en  = rd_q;
  assign mem_wr_en  = wr_q;
  assign mem_wdata  = wdata_q;
  assign irq        = irq_q;
  assign last_cmd   = lcmd_q;
  assign last_addr  = laddr_q;
  assign data_phase = cs_act && (hdr_q == CNT_W'(HDR));
  assign bit_idx    = bit_q;
  assign is_read    = cmd_ok_q && (kind == KIND_READ);

  // R1: an idle select line never lets a strobe through
  assert_idle_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !(mem_rd_en || mem_wr_en));

  // R4: a write strobe only ever belongs to a write command
  assert_write_needs_write_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (kind == KIND_WRITE));

  // R6: mailbox commands never reach the RAM
  assert_mailbox_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> (kind != KIND_MAILBOX));

  // R7: interrupt is one cycle long and follows the end of a frame
  assert_irq_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cs_end));

endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              data_phase,
  input  logic [$clog2(DATA_W)-1:0] bit_idx,
  input  logic              is_read,
  input  logic              rd_issued,
  input  logic [DATA_W-1:0] rdata,
  output logic              miso,
  output logic              miso_oe
);

  logic              pend_q, pend_n;
  logic [DATA_W-1:0] buf_q, buf_n;
  logic [DATA_W-1:0] tx_q, tx_n;
  logic              oe_q, oe_n;

  always_comb begin
    pend_n = rd_issued;
    buf_n  = pend_q ? rdata : buf_q;
    tx_n   = tx_q;
    oe_n   = oe_q;
    if (!cs_act) begin
      tx_n = '0;
      oe_n = 1'b0;
    end else if (sck_fall && data_phase && is_read) begin
      if (bit_idx == '0) begin
        tx_n = buf_q;
        oe_n = 1'b1;
      end else begin
        tx_n = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      buf_q  <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      pend_q <= pend_n;
      buf_q  <= buf_n;
      tx_q   <= tx_n;
      oe_q   <= oe_n;
    end
  end

  assign miso    = tx_q[DATA_W-1];
  assign miso_oe = oe_q;

  // R9: output is released whenever the select is idle
  assert_oe_released_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_oe);

  // R9: output is driven only for read commands
  assert_oe_only_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> is_read);

endmodule

// File: rtl/spi_mem_port.sv
module spi_mem_port #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cpu_irq,
  output logic [DATA_W-1:0] cpu_last_cmd,
  output logic [ADDR_W-1:0] cpu_last_addr
);

  localparam int BIT_W = $clog2(DATA_W);

  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic [2:0] pins_s;
  logic       csn_s, sck_s, mosi_s;
  logic       csn_q, sck_q;
  logic       cs_act, cs_end, sck_rise, sck_fall;
  logic       data_phase, is_read;
  logic [BIT_W-1:0] bit_idx;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  spi_pin_sync #(
    .N_PINS (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_sn),
    .pin_in  ({spi_csn, spi_sck, spi_mosi}),
    .pin_sync(pins_s)
  );
  assign {csn_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      csn_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      csn_q <= csn_s;
      sck_q <= sck_s;
    end
  end

  assign cs_act   = !csn_s;
  assign cs_end   = csn_s && !csn_q;
  assign sck_rise = cs_act && sck_s && !sck_q;
  assign sck_fall = cs_act && !sck_s && sck_q;

  spi_rx_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cs_act    (cs_act),
    .cs_end    (cs_end),
    .sck_rise  (sck_rise),
    .mosi_bit  (mosi_s),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_wdata (mem_wdata),
    .irq       (cpu_irq),
    .last_cmd  (cpu_last_cmd),
    .last_addr (cpu_last_addr),
    .data_phase(data_phase),
    .bit_idx   (bit_idx),
    .is_read   (is_read)
  );

  spi_tx_path #(
    .DATA_W(DATA_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cs_act    (cs_act),
    .sck_fall  (sck_fall),
    .data_phase(data_phase),
    .bit_idx   (bit_idx),
    .is_read   (is_read),
    .rd_issued (mem_rd_en),
    .rdata     (mem_rdata),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

endmodule

// File: tb/sim_spi_mem_port.sv
module sim_spi_mem_port;

  localparam int H = 8;  // system clocks per serial clock phase

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_csn = 1'b1;
  logic        spi_sck = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [15:0] mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        cpu_irq;
  logic [7:0]  cpu_last_cmd;
  logic [15:0] cpu_last_addr;

  int n_checks = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  int idle_cnt = 0;
  logic [23:0] exp_wr[$];
  logic [15:0] exp_rd[$];
  logic [7:0]  m_lcmd = 8'h00;
  logic [15:0] m_laddr = 16'h0000;

  always #2.5 clk = ~clk;

  spi_mem_port u0 (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cpu_irq(cpu_irq),
    .cpu_last_cmd(cpu_last_cmd), .cpu_last_addr(cpu_last_addr)
  );

  function automatic logic [7:0] ram_val(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int j);
    return seed + 8'(j * 29);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // RAM model: one cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rdata <= ram_val(mem_addr);

  // Per-clock comparison against the expected strobe queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wr_en) begin
        if (exp_wr.size() == 0) chk(1'b0, "R4/R5/R6 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
        else begin
          logic [23:0] e;
          e = exp_wr.pop_front();
          chk({mem_addr, mem_wdata} == e, "R4 write strobe", {8'h0, mem_addr, mem_wdata}, {8'h0, e});
        end
      end
      if (mem_rd_en) begin
        if (exp_rd.size() == 0) chk(1'b0, "R1/R6/R8 unexpected read", {16'h0, mem_addr}, 32'h0);
        else begin
          logic [15:0] e;
          e = exp_rd.pop_front();
          chk(mem_addr == e, "R3 read address", {16'h0, mem_addr}, {16'h0, e});
        end
      end
      if (cpu_irq) irq_cnt++;
      idle_cnt = spi_csn ? idle_cnt + 1 : 0;
      if (idle_cnt >= 4) chk(!spi_miso_oe, "R1 output released while idle", {31'h0, spi_miso_oe}, 32'h0);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [15:0] addr,
                      input int nbits, input logic [7:0] seed);
    int   nfull;
    bit   iswr, isrd, exp_irq, oe_bad, oe_miss;
    logic [7:0] rxb;
    nfull   = (nbits >= 24) ? (nbits - 24) / 8 : 0;
    iswr    = (cmd[7:6] == 2'b10);
    isrd    = (cmd[7:6] == 2'b11);
    exp_irq = (nbits >= 8) && (cmd != 8'hC0) && (cmd != 8'h80);
    if (nbits >= 24 && iswr)
      for (int j = 0; j < nfull; j++) exp_wr.push_back({addr + 16'(j), dbyte(seed, j)});
    if (nbits >= 24 && isrd)
      for (int j = 0; j <= nfull; j++) exp_rd.push_back(addr + 16'(j));
    if (nbits >= 8)  m_lcmd = cmd;
    if (nbits >= 24) m_laddr = addr;
    irq_cnt = 0;
    oe_bad  = 1'b0;
    oe_miss = 1'b0;
    rxb     = 8'h00;
    spi_csn = 1'b0;
    wait_clk(H);
    for (int k = 0; k < nbits; k++) begin
      if (k < 8)       spi_mosi = cmd[7-k];
      else if (k < 24) spi_mosi = addr[23-k];
      else begin
        logic [7:0] d;
        d = dbyte(seed, (k - 24) / 8);
        spi_mosi = d[7 - ((k - 24) % 8)];
      end
      wait_clk(H);
      if (isrd && k >= 24) begin
        if (!spi_miso_oe) oe_miss = 1'b1;
        rxb = {rxb[6:0], spi_miso};
        if ((k - 24) % 8 == 7) begin
          logic [15:0] ba;
          ba = addr + 16'((k - 24) / 8);
          chk(rxb == ram_val(ba), "R3 read byte on serial output", {24'h0, rxb}, {24'h0, ram_val(ba)});
        end
      end else if (spi_miso_oe) oe_bad = 1'b1;
      spi_sck = 1'b1;
      wait_clk(H);
      spi_sck = 1'b0;
    end
    wait_clk(H);
    spi_csn  = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(3 * H);
    chk(!oe_bad, "R9 output enable outside read data", {31'h0, oe_bad}, 32'h0);
    if (isrd && nfull > 0) chk(!oe_miss, "R9 output enable in read data", {31'h0, oe_miss}, 32'h0);
    chk(exp_wr.size() == 0, "R4/R5 write strobes missing", exp_wr.size(), 32'h0);
    chk(exp_rd.size() == 0, "R3/R8 read strobes missing", exp_rd.size(), 32'h0);
    chk(irq_cnt == int'(exp_irq), "R7/R8 interrupt pulses", irq_cnt, {31'h0, exp_irq});
    chk(cpu_last_cmd == m_lcmd, "R2/R8 last command", {24'h0, cpu_last_cmd}, {24'h0, m_lcmd});
    chk(cpu_last_addr == m_laddr, "R2/R8 last address", {16'h0, cpu_last_addr}, {16'h0, m_laddr});
  endtask

  initial begin
    wait_clk(150000);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    // R1: reset state
    chk({spi_miso_oe, mem_rd_en, mem_wr_en, cpu_irq} == 4'b0, "R1 reset outputs",
        {28'h0, spi_miso_oe, mem_rd_en, mem_wr_en, cpu_irq}, 32'h0);
    chk(cpu_last_cmd == 8'h00 && cpu_last_addr == 16'h0000, "R1 reset registers",
        {8'h0, cpu_last_cmd, cpu_last_addr}, 32'h0);

    // R1: clock and data activity with select high
    irq_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      spi_mosi = i[1];
      spi_sck  = ~spi_sck;
      wait_clk(H);
    end
    spi_sck = 1'b0;
    wait_clk(2 * H);
    chk(irq_cnt == 0, "R1 no interrupt while idle", irq_cnt, 32'h0);
    chk(cpu_last_cmd == 8'h00, "R1 last command untouched", {24'h0, cpu_last_cmd}, 32'h0);

    xfer(8'h85, 16'h1234, 24 + 3 * 8, 8'h3C);  // R4 write burst with interrupt
    xfer(8'h80, 16'hFFFF, 24 + 2 * 8, 8'hE1);  // R4 wrap, R7 quiet write
    xfer(8'hC3, 16'h0100, 24 + 4 * 8, 8'h00);  // R3 read burst with interrupt
    xfer(8'hC0, 16'hFFFE, 24 + 3 * 8, 8'h00);  // R3 wrap, R7 quiet read
    xfer(8'h81, 16'h2000, 24 + 8 + 5, 8'h77);  // R5 partial byte dropped
    xfer(8'h3C, 16'h5555, 24 + 2 * 8, 8'h99);  // R6 mailbox, data ignored
    xfer(8'h47, 16'hAAAA, 8, 8'h00);           // R7 command-only frame
    xfer(8'h12, 16'h0F0F, 5, 8'h00);           // R8 incomplete command
    xfer(8'hFF, 16'hBEEF, 20, 8'h00);          // R8 incomplete address
    xfer(8'hDA, 16'h7FFF, 24 + 8 + 3, 8'h00);  // R3 read cut mid byte

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule